// File: doc/BRIEF.md
# Station Address Update and EEPROM Persistence Sequencer

The block takes a new 48-bit station address, loads it into the live address registers, and then, only if persistence is enabled, stores it in a serial EEPROM. The address goes into the EEPROM as three 16-bit words at fixed word addresses. It drives an external serial EEPROM master through a simple request/done handshake. That master runs the wire protocol. It supplies a write-enable command, a word write and a word read.

Each stored word follows a fixed pattern: write-enable, write, then read back the same location. If the readback matches, the sequencer moves to the next word. If it does not match, the whole attempt is repeated, with at most three attempts per word. A word that never verifies sets its bit in a failure mask, and the sequencer still goes on to the remaining words. A one-cycle done pulse closes every accepted request. Requests that arrive while a sequence is running are ignored.

Top module: `mac_persist_seq`

## Requirements
- R1: After reset, station_addr is 0, fail_mask is 0, and busy, done and mw_req are all low.
- R2: A request (upd_req high while busy is low) is accepted. On the next clock edge, station_addr takes the value of upd_addr, whatever persist_en is.
- R3: When persist_en is low at acceptance, no serial operation is requested. busy and done are both high for exactly the one cycle after acceptance, and fail_mask reads 0.
- R4: Octet k of the address is upd_addr[47-8k -: 8]. Word i (i = 0..2) is {octet 2i+1, octet 2i}, so the earlier octet sits in bits 7:0. Word i is written at EEPROM word address 7+i, and the words go out in the order 0, 1, 2.
- R5: mw_op encodes 01 as write-enable, 10 as word write and 11 as word read. Every word write is immediately preceded by a write-enable operation.
- R6: Every word write is followed by a read of the same address. A readback equal to the written word ends the work on that word.
- R7: A word gets at most 3 write-and-verify attempts. After a third mismatch, the sequencer moves on to the next word.
- R8: fail_mask is cleared on acceptance. At done, bit i is 1 exactly when word i never verified. fail_mask holds its value until the next acceptance.
- R9: done is a single-cycle pulse. busy stays high from the cycle after acceptance through the done cycle, and then falls.
- R10: upd_req while busy is high is ignored. station_addr, the serial traffic and fail_mask are unaffected.
- R11: mw_req stays high, with mw_op, mw_addr and mw_wdata stable, until the cycle in which mw_done pulses. It is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_req | input | 1 | Request to install upd_addr |
| upd_addr | input | 48 | New station address, first octet in bits 47:40 |
| persist_en | input | 1 | Also store the address in the EEPROM |
| station_addr | output | 48 | Live station address registers |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail_mask | output | 3 | Words that never verified |
| mw_req | output | 1 | Operation request to the serial master |
| mw_op | output | 2 | Operation code (01 enable, 10 write, 11 read) |
| mw_addr | output | 6 | EEPROM word address |
| mw_wdata | output | 16 | Word to write |
| mw_done | input | 1 | Serial master finished the current operation |
| mw_rdata | input | 16 | Word read, valid with mw_done |

## Verification
station_addr is due one edge after the accepting edge. The bench drives the request at a falling edge and checks the registers at the next falling edge, where it also checks busy and, with persistence off, done. Serial operations are spaced by the master model's random 1 to 4 cycle latency, plus one decision cycle with mw_req low after each mw_done. For that reason the bench waits for done instead of counting cycles, then compares fail_mask, the per-word write and read counts, and the stored words against values computed from the injected readback faults. The done pulse width is checked at the falling edge after done.

// File: rtl/mac_seq_pkg.sv
// Shared encodings for the station-address persistence sequencer.
// Assumes: the serial master decodes mw_op with exactly these codes.
package mac_seq_pkg;
    typedef enum logic [1:0] {
        MW_NOP   = 2'b00,
        MW_WEN   = 2'b01,
        MW_WRITE = 2'b10,
        MW_READ  = 2'b11
    } mw_op_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'b00,
        S_LAUNCH = 2'b01,
        S_STEP   = 2'b10,
        S_FINISH = 2'b11
    } seq_state_t;
endpackage

// File: rtl/mac_addr_regs.sv
// Live station-address registers, one register per octet.
// Assumes: load is a single-cycle strobe from the sequencer's accept logic.
module mac_addr_regs #(
    parameter int BYTES  = 6,
    parameter int BYTE_W = 8,
    localparam int TOT_W = BYTES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TOT_W-1:0] new_addr,
    output logic [TOT_W-1:0] live_addr
);
    for (genvar k = 0; k < BYTES; k++) begin : g_octet
        logic [BYTE_W-1:0] oct_q;
        // Purpose: capture octet k of the new address on an accepted request.
        always_ff @(posedge clk) begin
            if (!rst_n)
                oct_q <= '0;
            else if (load)
                oct_q <= new_addr[k*BYTE_W +: BYTE_W];
        end
        assign live_addr[k*BYTE_W +: BYTE_W] = oct_q;
    end
endmodule

// File: rtl/mac_word_packer.sv
// Splits the live address into EEPROM words with little-endian octet order
// and selects one of them. Octet 0 is the most significant octet of the
// address. Word i = {octet 2i+1, octet 2i}.
// Assumes: word_sel < WORDS; out-of-range selects return zero.
module mac_word_packer #(
    parameter int WORDS  = 3,
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int TOT_W  = WORDS * WORD_W,
    localparam int SEL_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [TOT_W-1:0]  addr,
    input  logic [SEL_W-1:0]  word_sel,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] words [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        localparam int LO_OCT = 2 * i;
        localparam int HI_OCT = 2 * i + 1;
        assign words[i] = {addr[TOT_W-1-HI_OCT*BYTE_W -: BYTE_W],
                           addr[TOT_W-1-LO_OCT*BYTE_W -: BYTE_W]};
    end

    // Purpose: select the word addressed by word_sel.
    always_comb begin
        word = '0;
        for (int i = 0; i < WORDS; i++)
            if (word_sel == SEL_W'(i))
                word = words[i];
    end
endmodule

// File: rtl/mac_persist_fsm.sv
// Control for the persistence sequence. For each word it issues
// write-enable, write and read-back, compares the readback with the
// expected word, and retries up to MAX_TRIES attempts. It records words
// that never verified and ends with a one-cycle done state.
// Assumes: the serial master answers every request with one mw_done pulse
// and accepts a new request only after mw_req has been low for one cycle.
module mac_persist_fsm
    import mac_seq_pkg::*;
#(
    parameter int WORDS     = 3,
    parameter int WORD_W    = 16,
    parameter int MAX_TRIES = 3,
    localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int TRY_W = $clog2(MAX_TRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              persist,
    input  logic              mw_done,
    input  logic [WORD_W-1:0] mw_rdata,
    input  logic [WORD_W-1:0] expect_word,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic              mw_req,
    output logic [1:0]        mw_op,
    output logic [SEL_W-1:0]  word_sel,
    output logic [WORDS-1:0]  fail_mask
);
    seq_state_t        state_q;
    mw_op_t            op_q;
    logic [TRY_W-1:0]  tries_q;
    logic [SEL_W-1:0]  word_q;
    logic [WORD_W-1:0] rd_q;
    logic [WORDS-1:0]  mask_q;
    logic              verified;
    logic              last_try;
    logic              last_word;

    assign accept    = (state_q == S_IDLE) && start;
    assign verified  = (rd_q == expect_word);
    assign last_try  = (tries_q == TRY_W'(MAX_TRIES - 1));
    assign last_word = (word_q == SEL_W'(WORDS - 1));

    // Purpose: sequence state, operation, attempt and word bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= MW_WEN;
            tries_q <= '0;
            word_q  <= '0;
            rd_q    <= '0;
            mask_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        mask_q  <= '0;
                        word_q  <= '0;
                        tries_q <= '0;
                        op_q    <= MW_WEN;
                        state_q <= persist ? S_LAUNCH : S_FINISH;
                    end
                end
                S_LAUNCH: begin
                    if (mw_done) begin
                        if (op_q == MW_READ)
                            rd_q <= mw_rdata;
                        state_q <= S_STEP;
                    end
                end
                S_STEP: begin
                    state_q <= S_LAUNCH;
                    case (op_q)
                        MW_WEN:   op_q <= MW_WRITE;
                        MW_WRITE: op_q <= MW_READ;
                        MW_READ: begin
                            op_q <= MW_WEN;
                            if (verified || last_try) begin
                                if (!verified)
                                    mask_q[word_q] <= 1'b1;
                                tries_q <= '0;
                                if (last_word)
                                    state_q <= S_FINISH;
                                else
                                    word_q <= word_q + 1'b1;
                            end else begin
                                tries_q <= tries_q + 1'b1;
                            end
                        end
                        default: state_q <= S_IDLE;
                    endcase
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Purpose: decode outputs from the sequence state.
    always_comb begin
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_FINISH);
        mw_req    = (state_q == S_LAUNCH);
        mw_op     = (state_q == S_LAUNCH) ? op_q : MW_NOP;
        word_sel  = word_q;
        fail_mask = mask_q;
    end
endmodule

// File: rtl/mac_persist_seq.sv
// Top of the station-address update sequencer. It loads the live address
// registers on an accepted request and, when persistence is enabled,
// stores the address in the EEPROM through the serial master handshake.
// Assumes: upd_addr is valid in the cycle upd_req is high. The serial
// master is a separate block.
module mac_persist_seq #(
    parameter int ADDR_BYTES = 6,
    parameter int EE_ADDR_W  = 6,
    parameter int EE_BASE    = 7,
    parameter int MAX_TRIES  = 3,
    localparam int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int WORDS  = ADDR_BYTES / 2,
    localparam int MAC_W  = ADDR_BYTES * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_req,
    input  logic [MAC_W-1:0]     upd_addr,
    input  logic                 persist_en,
    output logic [MAC_W-1:0]     station_addr,
    output logic                 busy,
    output logic                 done,
    output logic [WORDS-1:0]     fail_mask,
    output logic                 mw_req,
    output logic [1:0]           mw_op,
    output logic [EE_ADDR_W-1:0] mw_addr,
    output logic [WORD_W-1:0]    mw_wdata,
    input  logic                 mw_done,
    input  logic [WORD_W-1:0]    mw_rdata
);
    localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic              accept;
    logic [SEL_W-1:0]  word_sel;
    logic [WORD_W-1:0] cur_word;

    mac_addr_regs #(.BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .new_addr  (upd_addr),
        .live_addr (station_addr)
    );

    mac_word_packer #(.WORDS(WORDS), .BYTE_W(BYTE_W)) u_pack (
        .addr     (station_addr),
        .word_sel (word_sel),
        .word     (cur_word)
    );

    mac_persist_fsm #(.WORDS(WORDS), .WORD_W(WORD_W), .MAX_TRIES(MAX_TRIES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (upd_req),
        .persist     (persist_en),
        .mw_done     (mw_done),
        .mw_rdata    (mw_rdata),
        .expect_word (cur_word),
        .accept      (accept),
        .busy        (busy),
        .done        (done),
        .mw_req      (mw_req),
        .mw_op       (mw_op),
        .word_sel    (word_sel),
        .fail_mask   (fail_mask)
    );

    assign mw_addr  = EE_ADDR_W'(EE_BASE) + EE_ADDR_W'(word_sel);
    assign mw_wdata = cur_word;
endmodule

// File: rtl/mac_persist_seq_chk.sv
// Assertion checker for mac_persist_seq, bound to every instance.
// Assumes: the same parameter values as the bound instance.
module mac_persist_seq_chk #(
    parameter int ADDR_BYTES = 6,
    parameter int EE_ADDR_W  = 6,
    parameter int EE_BASE    = 7,
    parameter int MAX_TRIES  = 3,
    localparam int WORDS  = ADDR_BYTES / 2,
    localparam int MAC_W  = ADDR_BYTES * 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 upd_req,
    input logic [MAC_W-1:0]     upd_addr,
    input logic                 persist_en,
    input logic [MAC_W-1:0]     station_addr,
    input logic                 busy,
    input logic                 done,
    input logic [WORDS-1:0]     fail_mask,
    input logic                 mw_req,
    input logic [1:0]           mw_op,
    input logic [EE_ADDR_W-1:0] mw_addr,
    input logic [15:0]          mw_wdata,
    input logic                 mw_done
);
    // R2: an accepted request installs the address on the next edge
    p_live_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && !busy) |=> (station_addr == $past(upd_addr)));

    // R3: persistence off gives an immediate done with a clean mask
    p_no_persist_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && !busy && !persist_en) |=> (done && !mw_req && fail_mask == '0));

    // R4: serial traffic stays within the reserved word addresses
    p_addr_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mw_req |-> (mw_addr >= EE_ADDR_W'(EE_BASE) && mw_addr < EE_ADDR_W'(EE_BASE + WORDS)));

    // R9: done lasts one cycle and busy falls right after it
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: serial requests only happen inside a busy window
    p_req_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mw_req |-> busy);

    // R10: requests during a sequence leave the live address alone
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(station_addr));

    // R8: the mask holds between sequences
    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !upd_req) |=> $stable(fail_mask));

    // R11: an open request keeps its fields until the master answers
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_req && !mw_done) |=> (mw_req && $stable(mw_op) && $stable(mw_addr) && $stable(mw_wdata)));

    // R11: the request drops for a cycle after each completion
    p_req_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_req && mw_done) |=> !mw_req);
endmodule

bind mac_persist_seq mac_persist_seq_chk #(
    .ADDR_BYTES(ADDR_BYTES),
    .EE_ADDR_W (EE_ADDR_W),
    .EE_BASE   (EE_BASE),
    .MAX_TRIES (MAX_TRIES)
) chk_i (.*);

// File: tb/mac_persist_seq_tb_top.sv
// Bench for mac_persist_seq. It contains a serial-master model with random
// latency and injectable readback faults, plus directed and random cases.
module mac_persist_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_req = 1'b0;
    logic [47:0] upd_addr = '0;
    logic        persist_en = 1'b0;
    logic [47:0] station_addr;
    logic        busy, done;
    logic [2:0]  fail_mask;
    logic        mw_req;
    logic [1:0]  mw_op;
    logic [5:0]  mw_addr;
    logic [15:0] mw_wdata;
    logic        mw_done = 1'b0;
    logic [15:0] mw_rdata = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_persist_seq dut_i (
        .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .upd_addr(upd_addr),
        .persist_en(persist_en), .station_addr(station_addr), .busy(busy),
        .done(done), .fail_mask(fail_mask), .mw_req(mw_req), .mw_op(mw_op),
        .mw_addr(mw_addr), .mw_wdata(mw_wdata), .mw_done(mw_done),
        .mw_rdata(mw_rdata)
    );

    // Serial master model state
    logic [15:0] mem [64];
    int fail_n [3];
    int writes [3];
    int reads [3];
    int ops_total;
    int wen_viol;
    int hs_viol;
    int order_viol;
    int last_word_wr;
    bit wen_armed;
    bit just_done;
    int cnt;
    logic [1:0]  op_l;
    logic [5:0]  addr_l;
    logic [15:0] data_l;

    initial cnt = 0;

    // Serial master model: random latency, one mw_done pulse per operation
    always @(posedge clk) begin
        mw_done <= 1'b0;
        if (just_done && mw_req) hs_viol++;
        just_done = mw_done;
        if (cnt > 0) begin
            if (!mw_req) hs_viol++;
            cnt = cnt - 1;
            if (cnt == 0) begin
                int w;
                w = int'(addr_l) - BASE;
                mw_done <= 1'b1;
                case (op_l)
                    2'b01: wen_armed = 1;
                    2'b10: begin
                        if (!wen_armed) wen_viol++;
                        wen_armed = 0;
                        mem[addr_l] = data_l;
                        if (w >= 0 && w < 3) begin
                            if (w < last_word_wr) order_viol++;
                            last_word_wr = w;
                            writes[w]++;
                        end
                    end
                    2'b11: begin
                        if (w >= 0 && w < 3) begin
                            reads[w]++;
                            mw_rdata <= (writes[w] <= fail_n[w]) ? ~mem[addr_l] : mem[addr_l];
                        end else
                            mw_rdata <= mem[addr_l];
                    end
                    default: hs_viol++;
                endcase
            end
        end else if (mw_req && !mw_done) begin
            op_l   = mw_op;
            addr_l = mw_addr;
            data_l = mw_wdata;
            ops_total++;
            cnt = int'($urandom_range(1, 4));
        end
    end

    function automatic logic [15:0] pack_word(logic [47:0] a, int i);
        logic [7:0] lo, hi;
        lo = a[47 - 16*i -: 8];
        hi = a[39 - 16*i -: 8];
        return {hi, lo};
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_case(logic [47:0] a, bit pen, int f0, int f1, int f2, bit poke);
        logic [2:0] exp_mask;
        bit seen;
        fail_n[0] = f0; fail_n[1] = f1; fail_n[2] = f2;
        for (int i = 0; i < 3; i++) begin
            writes[i] = 0; reads[i] = 0; mem[BASE+i] = 16'hDEAD;
        end
        ops_total = 0; wen_viol = 0; hs_viol = 0; order_viol = 0;
        last_word_wr = 0; wen_armed = 0;
        @(negedge clk);
        upd_addr = a; persist_en = pen; upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        chk(station_addr == a, "R2 live address load", station_addr, a);
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
        chk(done == !pen, "R3 done timing", done, !pen);
        seen = done;
        for (int c = 0; c < 3000 && !seen; c++) begin
            if (poke && c == 4) begin
                upd_addr = ~a; upd_req = 1'b1;
            end else
                upd_req = 1'b0;
            @(negedge clk);
            seen = done;
        end
        upd_req = 1'b0;
        chk(seen, "R9 done reached", seen, 1);
        exp_mask = '0;
        for (int i = 0; i < 3; i++) begin
            int exp_w;
            exp_w = pen ? ((fail_n[i] + 1 < 3) ? fail_n[i] + 1 : 3) : 0;
            if (pen && fail_n[i] >= 3) exp_mask[i] = 1'b1;
            chk(writes[i] == exp_w, "R7 attempts per word", writes[i], exp_w);
            chk(reads[i] == writes[i], "R6 readback per write", reads[i], writes[i]);
            if (pen)
                chk(mem[BASE+i] == pack_word(a, i), "R4 stored word", mem[BASE+i], pack_word(a, i));
        end
        chk(fail_mask == exp_mask, "R8 fail mask", fail_mask, exp_mask);
        if (!pen) chk(ops_total == 0, "R3 no serial ops", ops_total, 0);
        chk(wen_viol == 0, "R5 write-enable before write", wen_viol, 0);
        chk(order_viol == 0, "R4 word order", order_viol, 0);
        chk(hs_viol == 0, "R11 handshake", hs_viol, 0);
        chk(station_addr == a, "R10 busy request ignored", station_addr, a);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9 done one cycle", {done, busy}, 0);
        chk(fail_mask == exp_mask, "R8 mask held", fail_mask, exp_mask);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < 3; i++) begin fail_n[i] = 0; writes[i] = 0; reads[i] = 0; end
        ops_total = 0; wen_viol = 0; hs_viol = 0; order_viol = 0;
        last_word_wr = 0; wen_armed = 0; just_done = 0;
        repeat (3) @(negedge clk);
        chk(station_addr == '0, "R1 reset address", station_addr, 0);
        chk(fail_mask == '0, "R1 reset mask", fail_mask, 0);
        chk({busy, done, mw_req} == 3'b000, "R1 reset controls", {busy, done, mw_req}, 0);
        rst_n = 1'b1;
        // Directed corner cases
        run_case(48'h001122334455, 1'b0, 0, 0, 0, 1'b0);
        run_case(48'h001122334455, 1'b1, 0, 0, 0, 1'b0);
        run_case(48'hA1B2C3D4E5F6, 1'b1, 2, 0, 1, 1'b1);
        run_case(48'hFFFFFFFF0000, 1'b1, 3, 0, 3, 1'b0);
        run_case(48'h0123456789AB, 1'b1, 3, 3, 3, 1'b1);
        // Random cases
        for (int n = 0; n < 30; n++) begin
            logic [47:0] ra;
            ra = {$urandom, $urandom};
            run_case(ra, ($urandom_range(0, 3) != 0),
                     int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                     int'($urandom_range(0, 3)), $urandom_range(0, 1) == 1);
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule